// File: doc/BRIEF.md
# Mains Filter Capacitor Discharge Sequencer

This block decides when an active discharge current may be applied to the capacitor that sits across the mains input filter. While the line is present it periodically probes a sensing node with a rising staircase of small test currents and watches a line zero-crossing comparator. Seeing a crossing proves the line is there. The staircase then stops at once and the block rests for a long quiet interval. If the whole staircase passes with no crossing, the line is taken as removed. An AC-loss flag is latched, the discharge current is switched on for a capped window, and a blanking interval with no current follows before probing starts again.

All timing comes from a 1 ms tick enable. Every duration is a parameter counted in ticks, so a bench can shorten them. At power-up, once the bias supply first reports ready, the block sources a small probe current until the run signal first goes high. If the pin-low comparator reports a grounded sensing pin during that window, the function is switched off for good. After that start, the sequencer ignores the bias and run inputs, so supply restart cycles caused by converter faults do not disturb it. Only its own reset returns it to the power-up state.

Top module: `xcap_discharge_seq`

## Requirements
- R1: While reset is asserted and directly after it, all outputs are low: probe, test-current enable, step code, discharge enable, AC-loss flag and disabled flag.
- R2: The probe output is high from the cycle after `bias_ok_i` is first seen high until `run_i` is first seen high. Test currents start at step code 0 two clock edges after `run_i` is first high, and not before.
- R3: If `pin_low_i` is high while the probe is active, `disabled_o` sets and stays set until reset. Probe, test-current and discharge outputs then stay low. `pin_low_i` has no effect once probing has ended.
- R4: The step code is 0, 1, 2 or 3, for the lowest to the highest test level. Levels 0, 1 and 2 each last exactly STEP_TICKS ticks, and each advances to the next level when no zero-crossing event occurs.
- R5: Level 3 lasts LAST_TICKS ticks. When it expires with no event, the test current goes off and the discharge enable comes on in the same cycle. The AC-loss flag sets in that cycle.
- R6: Discharge lasts exactly DISCH_TICKS ticks. A quiet interval of WAIT_TICKS ticks with no current follows. Detection then restarts at step code 0, and the AC-loss flag stays set.
- R7: A zero-crossing event during detection turns off the test current and starts a quiet interval of WAIT_TICKS ticks. It also clears the AC-loss flag. Events during discharge or a quiet interval have no effect.
- R8: If a zero-crossing event arrives in the same cycle as the tick that ends level 3, the event wins. The block enters the quiet interval and no discharge occurs.
- R9: The test-current enable and the discharge enable are never high in the same cycle. The step code reads 0 whenever the test-current enable is low.
- R10: The crossing input is synchronized. Only a rising edge counts as an event, so a level held high counts once.
- R11: After the start, changes on `bias_ok_i` and `run_i` do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle 1 ms time base enable |
| zc_i | input | 1 | Line zero-crossing comparator output, asynchronous |
| bias_ok_i | input | 1 | Bias supply has reached its turn-on level |
| run_i | input | 1 | First-run signal that ends the startup probe |
| pin_low_i | input | 1 | Sensing pin is below the short-detect threshold |
| probe_en_o | output | 1 | Startup probe current enable |
| test_en_o | output | 1 | Staircase test-current enable |
| step_o | output | 2 | Test level code, 0 lowest to 3 highest |
| dis_en_o | output | 1 | Discharge current enable |
| loss_latch_o | output | 1 | AC-loss latch |
| disabled_o | output | 1 | Function permanently disabled |

## Verification
The critical coincidence is a synchronized zero-crossing edge that reaches the state logic in the same cycle as the tick that would end the last test level. The bench raises the crossing input two cycles before it drives that final tick, so both arrive at the same clock edge. It then requires the quiet state and a cleared loss flag, with no discharge. It also requires detection to restart at level 0 once the quiet interval has run out.

// File: rtl/xcd_pkg.sv
package xcd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DETECT = 2'd1,
    PH_DISCH  = 2'd2,
    PH_QUIET  = 2'd3
  } phase_t;

  localparam logic [1:0] TOP_STEP = 2'd3;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/xcd_sync_edge.sv
module xcd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/xcd_startup_gate.sv
module xcd_startup_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bias_ok_i,
  input  logic run_i,
  input  logic pin_low_i,
  output logic probe_o,
  output logic go_o,
  output logic disabled_o
);
  logic seen_q, seen_d;
  logic done_q, done_d;
  logic off_q, off_d;

  always_comb begin
    seen_d = seen_q;
    done_d = done_q;
    off_d  = off_q;
    if (!seen_q && bias_ok_i) begin
      seen_d = 1'b1;
    end
    if (seen_q && !done_q) begin
      if (pin_low_i) off_d = 1'b1;
      if (run_i) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      done_q <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      done_q <= done_d;
      off_q  <= off_d;
    end
  end

  assign probe_o    = seen_q & ~done_q & ~off_q;
  assign go_o       = done_q & ~off_q;
  assign disabled_o = off_q;
endmodule

// File: rtl/xcd_phase_timer.sv
module xcd_phase_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] last_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = tick_i & (cnt_q == last_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (done_o) cnt_d = '0;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xcap_discharge_seq.sv
module xcap_discharge_seq
  import xcd_pkg::*;
#(
  parameter int STEP_TICKS  = 12,
  parameter int LAST_TICKS  = 48,
  parameter int DISCH_TICKS = 300,
  parameter int WAIT_TICKS  = 700
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       zc_i,
  input  logic       bias_ok_i,
  input  logic       run_i,
  input  logic       pin_low_i,
  output logic       probe_en_o,
  output logic       test_en_o,
  output logic [1:0] step_o,
  output logic       dis_en_o,
  output logic       loss_latch_o,
  output logic       disabled_o
);
  localparam int MAXT = max4(STEP_TICKS, LAST_TICKS, DISCH_TICKS, WAIT_TICKS);
  localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [CW-1:0] L_STEP  = CW'(STEP_TICKS - 1);
  localparam logic [CW-1:0] L_LAST  = CW'(LAST_TICKS - 1);
  localparam logic [CW-1:0] L_DISCH = CW'(DISCH_TICKS - 1);
  localparam logic [CW-1:0] L_WAIT  = CW'(WAIT_TICKS - 1);

  phase_t        phase_q, phase_d;
  logic [1:0]    step_q, step_d;
  logic          latch_q, latch_d;
  logic          restart;
  logic          zc_evt;
  logic          go;
  logic          tmr_done;
  logic [CW-1:0] limit;

  xcd_sync_edge u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (zc_i),
    .rise_o  (zc_evt)
  );

  xcd_startup_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .bias_ok_i  (bias_ok_i),
    .run_i      (run_i),
    .pin_low_i  (pin_low_i),
    .probe_o    (probe_en_o),
    .go_o       (go),
    .disabled_o (disabled_o)
  );

  always_comb begin
    case (phase_q)
      PH_DETECT: limit = (step_q == TOP_STEP) ? L_LAST : L_STEP;
      PH_DISCH:  limit = L_DISCH;
      PH_QUIET:  limit = L_WAIT;
      default:   limit = L_STEP;
    endcase
  end

  xcd_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .clr_i  (restart),
    .last_i (limit),
    .done_o (tmr_done)
  );

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    latch_d = latch_q;
    restart = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        restart = 1'b1;
        if (go) begin
          phase_d = PH_DETECT;
          step_d  = 2'd0;
        end
      end
      PH_DETECT: begin
        if (zc_evt) begin
          phase_d = PH_QUIET;
          step_d  = 2'd0;
          latch_d = 1'b0;
          restart = 1'b1;
        end else if (tmr_done) begin
          if (step_q == TOP_STEP) begin
            phase_d = PH_DISCH;
            step_d  = 2'd0;
            latch_d = 1'b1;
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      PH_DISCH: begin
        if (tmr_done) phase_d = PH_QUIET;
      end
      PH_QUIET: begin
        if (tmr_done) begin
          phase_d = PH_DETECT;
          step_d  = 2'd0;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= 2'd0;
      latch_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      latch_q <= latch_d;
    end
  end

  assign test_en_o    = (phase_q == PH_DETECT);
  assign step_o       = test_en_o ? step_q : 2'd0;
  assign dis_en_o     = (phase_q == PH_DISCH);
  assign loss_latch_o = latch_q;
endmodule

// File: rtl/xcd_seq_chk.sv
module xcd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       probe_en_o,
  input logic       test_en_o,
  input logic [1:0] step_o,
  input logic       dis_en_o,
  input logic       loss_latch_o,
  input logic       disabled_o
);
  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_en_o && dis_en_o)); // R9

  AST_STEP_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en_o |-> (step_o == 2'd0)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    disabled_o |-> (!test_en_o && !dis_en_o && !probe_en_o)); // R3

  AST_DISABLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    disabled_o |=> disabled_o); // R3

  AST_DISCH_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_en_o) |-> loss_latch_o); // R5

  AST_DISCH_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_en_o) |-> ($past(test_en_o) && $past(step_o) == 2'd3)); // R5

  AST_STEP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en_o && $past(test_en_o) && step_o != $past(step_o))
      |-> (step_o == $past(step_o) + 2'd1)); // R4

  AST_PROBE_NO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    probe_en_o |-> (!test_en_o && !dis_en_o)); // R2
endmodule

bind xcap_discharge_seq xcd_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .probe_en_o   (probe_en_o),
  .test_en_o    (test_en_o),
  .step_o       (step_o),
  .dis_en_o     (dis_en_o),
  .loss_latch_o (loss_latch_o),
  .disabled_o   (disabled_o)
);

// File: tb/xcap_discharge_seq_bench.sv
module xcap_discharge_seq_bench;
  localparam int ST = 3;
  localparam int LT = 6;
  localparam int DT = 5;
  localparam int WT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, zc = 1'b0, bias_ok = 1'b0, run = 1'b0, pin_low = 1'b0;
  logic probe, test_en, dis_en, latch, disabled;
  logic [1:0] step;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  xcap_discharge_seq #(
    .STEP_TICKS(ST), .LAST_TICKS(LT), .DISCH_TICKS(DT), .WAIT_TICKS(WT)
  ) u_xcap_discharge_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .zc_i(zc), .bias_ok_i(bias_ok),
    .run_i(run), .pin_low_i(pin_low), .probe_en_o(probe), .test_en_o(test_en),
    .step_o(step), .dis_en_o(dis_en), .loss_latch_o(latch), .disabled_o(disabled)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic zc_pulse();
    zc = 1'b1;
    @(negedge clk);
    zc = 1'b0;
    cyc(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bias_ok = 1'b0; run = 1'b0; pin_low = 1'b0; zc = 1'b0; tick = 1'b0;
    cyc(3);
    chk("R1 test_en in reset", int'(test_en), 0);
    chk("R1 dis/probe/flags in reset", int'({probe, dis_en, latch, disabled, step}), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 outputs after reset", int'({probe, test_en, dis_en, latch, disabled, step}), 0);
  endtask

  task automatic t_startup();
    bias_ok = 1'b1;
    cyc(1);
    chk("R2 probe on after bias ok", int'(probe), 1);
    ticks(4);
    chk("R2 no test current before run", int'(test_en), 0);
    run = 1'b1;
    cyc(2);
    chk("R2 test starts after run", int'(test_en), 1);
    chk("R2 start at step 0", int'(step), 0);
    chk("R2 probe off after run", int'(probe), 0);
  endtask

  task automatic t_staircase();
    bias_ok = 1'b0; run = 1'b0; pin_low = 1'b1;
    ticks(ST - 1);
    chk("R4 step0 held", int'(step), 0);
    chk("R3 late pin_low ignored", int'(disabled), 0);
    pin_low = 1'b0;
    ticks(1);
    chk("R4 step1", int'(step), 1);
    chk("R11 still running without bias/run", int'(test_en), 1);
    ticks(ST);
    chk("R4 step2", int'(step), 2);
    ticks(ST);
    chk("R4 step3", int'(step), 3);
    ticks(LT - 1);
    chk("R5 step3 held", int'({test_en, step}), 7);
    ticks(1);
    chk("R5 discharge on", int'({test_en, dis_en}), 1);
    chk("R5 loss latched", int'(latch), 1);
    ticks(DT - 1);
    chk("R6 discharge held", int'(dis_en), 1);
    ticks(1);
    chk("R6 discharge ends", int'({test_en, dis_en}), 0);
    chk("R9 step zero when idle", int'(step), 0);
    ticks(WT - 1);
    chk("R6 blanking holds", int'({test_en, dis_en}), 0);
    ticks(1);
    chk("R6 detection restarts", int'({test_en, step}), 4);
    chk("R6 latch kept", int'(latch), 1);
  endtask

  task automatic t_zc_abort();
    ticks(ST);
    chk("R7 at step1 before event", int'(step), 1);
    zc_pulse();
    chk("R7 event stops test current", int'({test_en, dis_en}), 0);
    chk("R7 event clears latch", int'(latch), 0);
    ticks(WT - 1);
    chk("R7 wait holds", int'(test_en), 0);
    ticks(1);
    chk("R7 detection after wait", int'({test_en, step}), 4);
  endtask

  task automatic t_held_level();
    zc = 1'b1;
    cyc(3);
    chk("R10 edge aborts", int'(test_en), 0);
    ticks(WT);
    chk("R10 detect after wait", int'(test_en), 1);
    ticks(ST);
    chk("R10 held level no new event", int'({test_en, step}), 5);
    zc = 1'b0;
    cyc(3);
    ticks(WT);
  endtask

  task automatic t_race();
    ticks(ST - 1);
    zc_pulse();
    ticks(WT);
    ticks(3 * ST + LT - 1);
    chk("R8 at last tick of step3", int'({test_en, step}), 7);
    zc = 1'b1;
    @(negedge clk);
    zc = 1'b0;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R8 event wins over final tick", int'({test_en, dis_en}), 0);
    chk("R8 no latch", int'(latch), 0);
    ticks(WT);
    chk("R8 restart at step 0", int'({test_en, step}), 4);
  endtask

  task automatic t_zc_in_discharge();
    ticks(3 * ST + LT);
    chk("R5 discharge reached", int'(dis_en), 1);
    ticks(2);
    zc_pulse();
    chk("R7 event ignored in discharge", int'({dis_en, latch}), 3);
    ticks(DT - 3);
    chk("R7 discharge full length", int'(dis_en), 1);
    ticks(1);
    chk("R7 discharge ends on time", int'(dis_en), 0);
    ticks(2);
    zc_pulse();
    chk("R7 event ignored in blanking", int'(latch), 1);
  endtask

  task automatic t_disable();
    do_reset();
    bias_ok = 1'b1;
    pin_low = 1'b1;
    cyc(2);
    chk("R3 disabled set", int'(disabled), 1);
    chk("R3 probe off", int'(probe), 0);
    pin_low = 1'b0;
    run = 1'b1;
    ticks(3 * ST + LT + 2);
    chk("R3 no currents when disabled", int'({probe, test_en, dis_en}), 0);
    chk("R3 disabled sticky", int'(disabled), 1);
  endtask

  initial begin
    do_reset();
    t_startup();
    t_staircase();
    t_zc_abort();
    t_held_level();
    t_race();
    t_zc_in_discharge();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule